// File: doc/BRIEF.md
# Equalizer Boost and Enable Control

This block converts board-level control pins and configuration register fields into the settings that drive one clock lane and a configurable number of data lanes of a cable equalizer. It decides where each data lane's 3-bit boost code comes from, whether the part is ACTIVE or in STANDBY, which lanes are powered, and which 2-bit output swing code applies to every lane. It also presents a packed status word, built from the settings actually in effect, which the register file returns on a status read.

The boost source is a multiplexer. When the force-boost pin is high, one pin code is shared by every data lane. When it is low, each data lane takes its own register field. The ACTIVE/STANDBY state follows a four-row table: an enable-source register bit selects whether the state follows the enable pin or a register standby bit. A lane is powered only when the device is ACTIVE and its own disable bit is clear. All outputs are registered: every output shows the inputs sampled at the previous rising clock edge. At board level the force-boost pin should be tied or pulled high and the boost pins pulled low, so that an unconfigured part applies pin code 000.

Top module: `eqc_top`

## Requirements
- R1: When `force_pin_i` is 1, every data lane's boost output equals `boost_pin_i`. The boost of data lane k sits at `boost_o[3k+2:3k]`.
- R2: When `force_pin_i` is 0, data lane k's boost output equals its register field `boost_reg_i[3k+2:3k]`, independently of the other lanes and of `boost_pin_i`.
- R3: All eight boost codes, from 000 (least boost) to 111 (most boost), pass through unchanged from either source.
- R4: When `en_src_i` is 0, `active_o` equals `en_pin_i` (1 = ACTIVE, 0 = STANDBY), and `standby_reg_i` has no effect.
- R5: When `en_src_i` is 1, `active_o` is the inverse of `standby_reg_i` (0 = ACTIVE, 1 = STANDBY), and `en_pin_i` has no effect.
- R6: `pwr_en_o[c]` is 1 only when the device is ACTIVE and `lane_dis_i[c]` is 0. Bit 0 is the clock lane, and bit k+1 is data lane k.
- R7: `amp_o` equals `amp_reg_i` and is shared by all lanes. The codes are 00 = 540, 01 = 770, 10 = 1000 and 11 = 1200 mVp-p.
- R8: `status_o` reports the settings in effect: bit 0 is `active_o`, bits [NUM_DATA+1:1] are `pwr_en_o`, and above these sit the data lane boost codes, lane 0 lowest.
- R9: While `rst` is high at a clock edge, the outputs become boost 000 on every lane, all lanes unpowered, STANDBY, and `amp_o` = 10.
- R10: Every output reflects the inputs sampled at the previous rising edge, which is one cycle of latency.
- R11: In STANDBY, every lane is unpowered, whatever the disable bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| boost_pin_i | input | 3 | Shared boost code from the pins |
| force_pin_i | input | 1 | 1 = pin code for all data lanes, 0 = per-lane register codes |
| en_pin_i | input | 1 | Enable pin, 1 = ACTIVE |
| en_src_i | input | 1 | State source, 0 = enable pin, 1 = register standby bit |
| standby_reg_i | input | 1 | Register standby bit, 1 = STANDBY |
| boost_reg_i | input | 3*NUM_DATA | Per-data-lane register boost codes |
| lane_dis_i | input | NUM_DATA+1 | Per-lane disable bits, 1 = disabled, bit 0 = clock lane |
| amp_reg_i | input | 2 | Output swing code |
| boost_o | output | 3*NUM_DATA | Boost code in effect for each data lane |
| pwr_en_o | output | NUM_DATA+1 | Lane power enables |
| active_o | output | 1 | Device state, 1 = ACTIVE, 0 = STANDBY |
| amp_o | output | 2 | Output swing code for all lanes |
| status_o | output | 3*NUM_DATA+NUM_DATA+2 | Packed status of the settings in effect |

## Verification
The boost path is driven by a sweep of all eight pin codes with force high, where distinct per-lane register values must not leak through. It is then driven with force low and a different code on every lane, which separates a swapped or shared field from a correct per-lane selection. The state logic is taken through all four table rows, with the unused control toggled against the chosen one, which shows which input actually governs the state. Disable masks are walked in both ACTIVE and STANDBY, and a long stretch of random stimulus, including resets in mid-run, is compared every clock against a behavioural model.

// File: rtl/eqc_pkg.sv
package eqc_pkg;
  localparam int BOOST_W_DEF = 3;
  localparam int AMP_W_DEF   = 2;
  localparam logic [AMP_W_DEF-1:0] AMP_RST = 2'b10;

  typedef enum logic {
    ST_STANDBY = 1'b0,
    ST_ACTIVE  = 1'b1
  } dev_state_e;
endpackage

// File: rtl/eqc_boost_sel.sv
module eqc_boost_sel #(
  parameter int NUM_DATA = 3,
  parameter int BOOST_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        force_pin_i,
  input  logic [BOOST_W-1:0]          pin_code_i,
  input  logic [NUM_DATA*BOOST_W-1:0] reg_codes_i,
  output logic [NUM_DATA*BOOST_W-1:0] codes_o
);
  for (genvar k = 0; k < NUM_DATA; k++) begin : g_lane
    logic [BOOST_W-1:0] code_q;

    always_ff @(posedge clk) begin
      if (rst) code_q <= '0;
      else if (force_pin_i) code_q <= pin_code_i;
      else code_q <= reg_codes_i[k*BOOST_W +: BOOST_W];
    end

    assign codes_o[k*BOOST_W +: BOOST_W] = code_q;

    // R1
    pin_share_chk: assert property (@(posedge clk) disable iff (rst)
      force_pin_i |=> codes_o[k*BOOST_W +: BOOST_W] == $past(pin_code_i));
    // R2
    reg_field_chk: assert property (@(posedge clk) disable iff (rst)
      !force_pin_i |=> codes_o[k*BOOST_W +: BOOST_W] == $past(reg_codes_i[k*BOOST_W +: BOOST_W]));
  end
endmodule

// File: rtl/eqc_state_ctl.sv
module eqc_state_ctl
  import eqc_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_src_i,
  input  logic              en_pin_i,
  input  logic              standby_reg_i,
  input  logic [NUM_CH-1:0] lane_dis_i,
  output logic              active_o,
  output logic [NUM_CH-1:0] pwr_en_o
);
  dev_state_e        state_nxt, state_q;
  logic [NUM_CH-1:0] pwr_q;

  always_comb begin
    if (en_src_i) state_nxt = standby_reg_i ? ST_STANDBY : ST_ACTIVE;
    else          state_nxt = en_pin_i ? ST_ACTIVE : ST_STANDBY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_STANDBY;
      pwr_q   <= '0;
    end else begin
      state_q <= state_nxt;
      pwr_q   <= {NUM_CH{state_nxt == ST_ACTIVE}} & ~lane_dis_i;
    end
  end

  assign active_o = (state_q == ST_ACTIVE);
  assign pwr_en_o = pwr_q;

  // R4
  pin_state_chk: assert property (@(posedge clk) disable iff (rst)
    !en_src_i |=> active_o == $past(en_pin_i));
  // R5
  reg_state_chk: assert property (@(posedge clk) disable iff (rst)
    en_src_i |=> active_o == !$past(standby_reg_i));
  // R11
  standby_off_chk: assert property (@(posedge clk) disable iff (rst)
    !active_o |-> $countones(pwr_en_o) == 0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R6
    lane_dis_chk: assert property (@(posedge clk) disable iff (rst)
      lane_dis_i[c] |=> !pwr_en_o[c]);
  end
endmodule

// File: rtl/eqc_top.sv
module eqc_top
  import eqc_pkg::*;
#(
  parameter int NUM_DATA = 3,
  parameter int BOOST_W  = BOOST_W_DEF,
  parameter int AMP_W    = AMP_W_DEF,
  localparam int NUM_CH  = NUM_DATA + 1,
  localparam int BST_ALL = NUM_DATA * BOOST_W,
  localparam int STAT_W  = BST_ALL + NUM_CH + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BOOST_W-1:0] boost_pin_i,
  input  logic               force_pin_i,
  input  logic               en_pin_i,
  input  logic               en_src_i,
  input  logic               standby_reg_i,
  input  logic [BST_ALL-1:0] boost_reg_i,
  input  logic [NUM_CH-1:0]  lane_dis_i,
  input  logic [AMP_W-1:0]   amp_reg_i,
  output logic [BST_ALL-1:0] boost_o,
  output logic [NUM_CH-1:0]  pwr_en_o,
  output logic               active_o,
  output logic [AMP_W-1:0]   amp_o,
  output logic [STAT_W-1:0]  status_o
);
  logic [AMP_W-1:0] amp_q;

  eqc_boost_sel #(.NUM_DATA(NUM_DATA), .BOOST_W(BOOST_W)) boost_sel_i (
    .clk         (clk),
    .rst         (rst),
    .force_pin_i (force_pin_i),
    .pin_code_i  (boost_pin_i),
    .reg_codes_i (boost_reg_i),
    .codes_o     (boost_o)
  );

  eqc_state_ctl #(.NUM_CH(NUM_CH)) state_ctl_i (
    .clk           (clk),
    .rst           (rst),
    .en_src_i      (en_src_i),
    .en_pin_i      (en_pin_i),
    .standby_reg_i (standby_reg_i),
    .lane_dis_i    (lane_dis_i),
    .active_o      (active_o),
    .pwr_en_o      (pwr_en_o)
  );

  always_ff @(posedge clk) begin
    if (rst) amp_q <= AMP_RST[AMP_W-1:0];
    else     amp_q <= amp_reg_i;
  end

  assign amp_o    = amp_q;
  assign status_o = {boost_o, pwr_en_o, active_o};

  // R7
  amp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> amp_o == $past(amp_reg_i));
  // R6
  pwr_needs_active_chk: assert property (@(posedge clk) disable iff (rst)
    (|pwr_en_o) |-> active_o);
endmodule

// File: tb/eqc_top_tb_top.sv
module eqc_top_tb_top;
  localparam int ND = 3;
  localparam int NC = ND + 1;
  localparam int SW = 3 * ND + NC + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0]    boost_pin_i = '0;
  logic          force_pin_i = 1'b1;
  logic          en_pin_i = 1'b1;
  logic          en_src_i = 1'b0;
  logic          standby_reg_i = 1'b0;
  logic [3*ND-1:0] boost_reg_i = '0;
  logic [NC-1:0] lane_dis_i = '0;
  logic [1:0]    amp_reg_i = 2'b10;
  logic [3*ND-1:0] boost_o;
  logic [NC-1:0] pwr_en_o;
  logic          active_o;
  logic [1:0]    amp_o;
  logic [SW-1:0] status_o;

  always #10 clk = ~clk;

  eqc_top #(.NUM_DATA(ND)) dut_i (
    .clk(clk), .rst(rst), .boost_pin_i(boost_pin_i), .force_pin_i(force_pin_i),
    .en_pin_i(en_pin_i), .en_src_i(en_src_i), .standby_reg_i(standby_reg_i),
    .boost_reg_i(boost_reg_i), .lane_dis_i(lane_dis_i), .amp_reg_i(amp_reg_i),
    .boost_o(boost_o), .pwr_en_o(pwr_en_o), .active_o(active_o), .amp_o(amp_o),
    .status_o(status_o)
  );

  // behavioural reference model
  int exp_boost[ND];
  int exp_pwr[NC];
  int exp_act, exp_amp;
  bit exp_in_rst = 1'b1;
  bit exp_forced = 1'b1;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    exp_in_rst <= rst;
    exp_forced <= force_pin_i;
    if (rst) begin
      for (int k = 0; k < ND; k++) exp_boost[k] <= 0;
      for (int c = 0; c < NC; c++) exp_pwr[c] <= 0;
      exp_act <= 0;
      exp_amp <= 2;
    end else begin
      int a;
      if (en_src_i) a = standby_reg_i ? 0 : 1;
      else          a = en_pin_i ? 1 : 0;
      exp_act <= a;
      for (int k = 0; k < ND; k++)
        exp_boost[k] <= force_pin_i ? int'(boost_pin_i) : int'((boost_reg_i >> (3 * k)) & 7);
      for (int c = 0; c < NC; c++) exp_pwr[c] <= (a == 1 && lane_dis_i[c] == 1'b0) ? 1 : 0;
      exp_amp <= int'(amp_reg_i);
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      longint st;
      string bt;
      bt = exp_in_rst ? "R9 boost" : (exp_forced ? "R1/R3 boost" : "R2/R3 boost");
      for (int k = 0; k < ND; k++) chk(bt, int'(boost_o[3*k +: 3]), exp_boost[k]);
      for (int c = 0; c < NC; c++)
        chk(exp_in_rst ? "R9 pwr" : (exp_act == 0 ? "R11 pwr" : "R6 pwr"), int'(pwr_en_o[c]), exp_pwr[c]);
      chk(exp_in_rst ? "R9 state" : "R4/R5/R10 state", int'(active_o), exp_act);
      chk(exp_in_rst ? "R9 amp" : "R7 amp", int'(amp_o), exp_amp);
      st = exp_act;
      for (int c = 0; c < NC; c++) st |= longint'(exp_pwr[c]) << (1 + c);
      for (int k = 0; k < ND; k++) st |= longint'(exp_boost[k]) << (1 + NC + 3 * k);
      chk("R8 status", int'(status_o), int'(st));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    // R1 / R3: pin sweep, distinct register codes must not leak
    boost_reg_i = {3'd5, 3'd2, 3'd7};
    force_pin_i = 1'b1;
    for (int v = 0; v < 8; v++) begin boost_pin_i = 3'(v); tick(); end
    // R2 / R3: per-lane register codes
    force_pin_i = 1'b0;
    boost_pin_i = 3'd6;
    for (int v = 0; v < 8; v++) begin
      boost_reg_i = {3'(v), 3'(7 - v), 3'(v ^ 3)};
      tick();
    end
    // R4 / R5: all table rows, unused control toggled
    for (int row = 0; row < 4; row++) begin
      en_src_i = row[1];
      if (row[1]) standby_reg_i = row[0]; else en_pin_i = row[0];
      for (int t = 0; t < 2; t++) begin
        if (row[1]) en_pin_i = t[0]; else standby_reg_i = t[0];
        tick();
      end
    end
    // R6 / R11: disable masks in ACTIVE and in STANDBY
    en_src_i = 1'b0;
    for (int s = 0; s < 2; s++) begin
      en_pin_i = s[0] ? 1'b0 : 1'b1;
      for (int m = 0; m < 16; m++) begin lane_dis_i = 4'(m); tick(); end
    end
    // R7: swing codes
    lane_dis_i = '0;
    en_pin_i = 1'b1;
    for (int a = 0; a < 4; a++) begin amp_reg_i = 2'(a); tick(); end
    // R9: reset in mid-run
    rst = 1'b1; tick(2); rst = 1'b0; tick();
    // R10: random stimulus compared every clock
    for (int i = 0; i < 400; i++) begin
      boost_pin_i   = 3'($urandom);
      force_pin_i   = 1'($urandom);
      en_pin_i      = 1'($urandom);
      en_src_i      = 1'($urandom);
      standby_reg_i = 1'($urandom);
      boost_reg_i   = 9'($urandom);
      lane_dis_i    = 4'($urandom);
      amp_reg_i     = 2'($urandom);
      rst           = ($urandom % 50) == 0;
      tick();
    end
    rst = 1'b0;
    tick(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule